// File: doc/BRIEF.md
# Retriggerable Digital One-Shot Timer

This block is a clocked monostable pulse generator. A qualified edge on either of two trigger inputs starts a single high pulse on `pulse`, with its complement on `pulse_n`. The pulse length is counted in clock cycles and taken from the parallel `width` input at the moment the trigger is accepted. One input fires on a rising edge while the other input is high. The second input fires on a falling edge while the first is low. This lets a design fire on either the leading or the trailing edge of a strobe.

A mode input picks one of two behaviours. In retriggerable mode, each accepted trigger restarts the full period, so the pulse is stretched. In one-shot mode, the pulse is timed from the first trigger and any trigger that arrives while it is high is dropped. Both trigger inputs pass through a synchroniser before edge detection, so they may be asynchronous to `clk`. An active-low reset clears the output immediately. Its release is synchronised to the clock, and after release the block waits for a short recovery before it accepts triggers.

Top module: `oneshot_timer`

## Requirements
- R1: A low-to-high change on `trig_rise` while `trig_fall_n` is high starts a pulse. If the input changes before clock edge k, `pulse` is high from edge k+2 (two synchroniser stages plus one output register).
- R2: A high-to-low change on `trig_fall_n` while `trig_rise` is low starts a pulse with the same latency. A rise on `trig_rise` while `trig_fall_n` is low starts no pulse. A fall on `trig_fall_n` while `trig_rise` is high starts no pulse. A fall of `trig_rise` or a rise of `trig_fall_n` starts no pulse.
- R3: A pulse lasts `width`+1 clock cycles, so a `width` of 0 gives a one-cycle pulse. `width` is captured when the trigger is accepted, and changing it during the pulse does not alter the length.
- R4: With `retrig_en`=1, an accepted trigger while `pulse` is high reloads the count, including a trigger landing in the pulse's last cycle. The pulse then ends `width`+1 cycles after the last trigger, with no low gap between the two pulses.
- R5: With `retrig_en`=0, triggers landing while `pulse` is high are ignored, including in its last cycle, so the length stays `width`+1. A trigger landing after `pulse` has fallen starts a new, separate pulse.
- R6: While `rst_n` is low, `pulse` is 0 and `pulse_n` is 1 without waiting for a clock edge. Trigger edges made while reset is low are lost.
- R7: The release of `rst_n` takes effect after two clock edges, and triggers are then blocked for three more cycles. A level held on an input across the release never counts as an edge, even if it changes in the same cycle as the release.
- R8: With `trig_rise` held low and `trig_fall_n` held high, no pulse ever occurs. `pulse_n` is always the complement of `pulse`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| trig_rise | input | 1 | Trigger on rising edge, qualified by `trig_fall_n` high |
| trig_fall_n | input | 1 | Trigger on falling edge, qualified by `trig_rise` low |
| retrig_en | input | 1 | 1 = retriggerable, 0 = one-shot (ignore triggers during pulse) |
| width | input | CNT_W | Pulse length minus one, in clock cycles |
| pulse | output | 1 | Timer output, high during the pulse |
| pulse_n | output | 1 | Complement of `pulse` |

## Verification
The hardest situations to reach from the ports are two races that each fall on one exact cycle. The first is a second trigger that lands in the very last high cycle of a pulse, where the two modes must diverge. The second is an input edge that coincides with reset release. The bench drives every input from a per-cycle schedule counted from the first trigger. This places the second edge at an offset equal to `width`, so it arrives exactly as the count reaches zero. The bench changes `rst_n` and `trig_rise` on the same falling clock edge, and it also holds inputs at active levels through the whole reset.

// File: rtl/ost_pkg.sv
package ost_pkg;
  typedef enum logic {
    MODE_ONCE   = 1'b0,
    MODE_RETRIG = 1'b1
  } retrig_mode_e;
endpackage

// File: rtl/ost_rst_sync.sv
module ost_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/ost_sync.sv
module ost_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         srst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stg_d;
      if (s == 0) begin : g_first
        always_comb stg_d = d;
      end else begin : g_rest
        always_comb stg_d = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n) stg_q[s] <= '0;
        else         stg_q[s] <= stg_d;
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/ost_trig.sv
module ost_trig #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic srst_n,
  input  logic rise_s,
  input  logic fall_n_s,
  output logic fire,
  output logic rdy
);
  localparam int PRIME = SYNC_STAGES + 1;

  logic             rise_d, fall_n_d;
  logic [PRIME-1:0] prime_q, prime_d;
  logic             rise_hit, fall_hit;

  always_comb begin
    prime_d  = {prime_q[PRIME-2:0], 1'b1};
    rise_hit = rise_s & ~rise_d & fall_n_s;
    fall_hit = fall_n_d & ~fall_n_s & ~rise_s;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rise_d   <= 1'b0;
      fall_n_d <= 1'b1;
      prime_q  <= '0;
    end else begin
      rise_d   <= rise_s;
      fall_n_d <= fall_n_s;
      prime_q  <= prime_d;
    end
  end

  assign rdy  = prime_q[PRIME-1];
  assign fire = rdy & (rise_hit | fall_hit);
endmodule

// File: rtl/ost_core.sv
module ost_core
  import ost_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             fire,
  input  retrig_mode_e     mode,
  input  logic [CNT_W-1:0] width,
  output logic             q
);
  logic             q_r, q_n;
  logic [CNT_W-1:0] cnt_r, cnt_n;
  logic             load, cnt_en;

  always_comb begin
    load   = fire & (~q_r | (mode == MODE_RETRIG));
    cnt_en = load | (q_r & (cnt_r != '0));
    q_n    = q_r;
    cnt_n  = cnt_r;
    if (load) begin
      q_n   = 1'b1;
      cnt_n = width;
    end else if (q_r) begin
      if (cnt_r == '0) q_n = 1'b0;
      else             cnt_n = cnt_r - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) q_r <= 1'b0;
    else         q_r <= q_n;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     cnt_r <= '0;
    else if (cnt_en) cnt_r <= cnt_n;
  end

  assign q = q_r;

  // R1
  start_pulse_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (fire && !q_r) |=> (q_r && cnt_r == $past(width)));
  // R4
  retrig_reload_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (fire && mode == MODE_RETRIG) |=> (q_r && cnt_r == $past(width)));
  // R5
  once_ignore_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (q_r && mode == MODE_ONCE && cnt_r != '0) |=> (q_r && cnt_r == $past(cnt_r) - 1'b1));
  // R3
  pulse_end_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (q_r && cnt_r == '0 && !(fire && mode == MODE_RETRIG)) |=> !q_r);
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import ost_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_rise,
  input  logic             trig_fall_n,
  input  logic             retrig_en,
  input  logic [CNT_W-1:0] width,
  output logic             pulse,
  output logic             pulse_n
);
  logic         srst_n;
  logic [1:0]   trig_s;
  logic         fire, rdy, q;
  retrig_mode_e mode;

  assign mode = retrig_mode_e'(retrig_en);

  ost_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  ost_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk(clk), .srst_n(srst_n), .d({trig_rise, trig_fall_n}), .q(trig_s)
  );

  ost_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk(clk), .srst_n(srst_n), .rise_s(trig_s[1]), .fall_n_s(trig_s[0]),
    .fire(fire), .rdy(rdy)
  );

  ost_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .srst_n(srst_n), .fire(fire), .mode(mode), .width(width), .q(q)
  );

  assign pulse   = q;
  assign pulse_n = ~q;

  // R7
  recovery_quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !rdy |=> !pulse);
endmodule

// File: tb/tb_oneshot_timer.sv
module tb_oneshot_timer;
  logic        clk = 1'b0;
  logic        rst_n, a, b, mode;
  logic [15:0] width;
  logic        q, qn;
  int          checks = 0, errors = 0, compl_bad = 0;
  bit          done = 0;

  oneshot_timer dut (
    .clk(clk), .rst_n(rst_n), .trig_rise(a), .trig_fall_n(b),
    .retrig_en(mode), .width(width), .pulse(q), .pulse_n(qn)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic [15:0] w;
    logic        md;
    logic        useb;
    logic [7:0]  off;
    logic [15:0] neww;
    logic [7:0]  exp_hi;
    logic [7:0]  exp_np;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{16'd5,  1'b1, 1'b0, 8'd0, 16'hFFFF, 8'd6,  8'd1, 4'd1}, // R1 basic rise
    '{16'd0,  1'b1, 1'b0, 8'd0, 16'hFFFF, 8'd1,  8'd1, 4'd3}, // R3 zero width
    '{16'd5,  1'b0, 1'b1, 8'd0, 16'hFFFF, 8'd6,  8'd1, 4'd2}, // R2 fall trigger
    '{16'd10, 1'b1, 1'b0, 8'd5, 16'hFFFF, 8'd16, 8'd1, 4'd4}, // R4 stretch
    '{16'd10, 1'b0, 1'b0, 8'd5, 16'hFFFF, 8'd11, 8'd1, 4'd5}, // R5 ignored
    '{16'd6,  1'b1, 1'b1, 8'd6, 16'hFFFF, 8'd13, 8'd1, 4'd4}, // R4 last-cycle reload
    '{16'd6,  1'b0, 1'b1, 8'd6, 16'hFFFF, 8'd7,  8'd1, 4'd5}, // R5 last-cycle ignore
    '{16'd3,  1'b0, 1'b0, 8'd8, 16'hFFFF, 8'd8,  8'd2, 4'd5}, // R5 second pulse
    '{16'd2,  1'b1, 1'b0, 8'd4, 16'hFFFF, 8'd6,  8'd2, 4'd4}, // R4 separate pulses
    '{16'd8,  1'b1, 1'b0, 8'd0, 16'd1,    8'd9,  8'd1, 4'd3}  // R3 width change
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic observe(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (q === 1'b1) hi++;
      if (qn !== ~q) compl_bad++;
    end
  endtask

  task automatic run_vec(input vec_t v);
    int hi = 0, np = 0, first = -1;
    logic prev = 1'b0;
    @(negedge clk);
    width = v.w;
    mode  = v.md;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (q === 1'b1) begin
        hi++;
        if (first < 0) first = i;
        if (!prev) np++;
      end
      if (qn !== ~q) compl_bad++;
      prev = q;
      if (i == 0 || (v.off != 0 && i == int'(v.off))) begin
        if (v.useb) b = 1'b0; else a = 1'b1;
      end
      if (i == 2 || (v.off != 0 && i == int'(v.off) + 2)) begin
        b = 1'b1; a = 1'b0;
      end
      if (i == 4 && v.neww != 16'hFFFF) width = v.neww;
    end
    chk(first == 3, "R1 latency", first, 3);
    chk(hi == int'(v.exp_hi), $sformatf("R%0d high cycles", v.rq), hi, int'(v.exp_hi));
    chk(np == int'(v.exp_np), $sformatf("R%0d pulse count", v.rq), np, int'(v.exp_np));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi;
    rst_n = 1'b0; a = 1'b0; b = 1'b1; mode = 1'b1; width = 16'd4;
    repeat (3) @(negedge clk);
    chk(q === 1'b0 && qn === 1'b1, "R6 reset state", q, 0);
    rst_n = 1'b1;
    observe(20, hi);
    chk(hi == 0, "R8 idle inputs", hi, 0);

    foreach (VEC[k]) run_vec(VEC[k]);

    // R2 wrongly qualified edges
    width = 16'd2; mode = 1'b1;
    @(negedge clk); b = 1'b0;
    observe(15, hi);
    chk(hi == 3, "R2 fall with rise low", hi, 3);
    @(negedge clk); a = 1'b1;
    observe(15, hi);
    chk(hi == 0, "R2 rise while fall_n low", hi, 0);
    @(negedge clk); b = 1'b1;
    observe(15, hi);
    chk(hi == 0, "R2 rise of fall_n", hi, 0);
    @(negedge clk); b = 1'b0;
    observe(15, hi);
    chk(hi == 0, "R2 fall while rise high", hi, 0);
    @(negedge clk); a = 1'b0; b = 1'b1;
    observe(15, hi);
    chk(hi == 0, "R2 fall of rise", hi, 0);

    // R6 asynchronous clear mid-pulse
    width = 16'd20;
    @(negedge clk); a = 1'b1;
    repeat (8) @(negedge clk);
    chk(q === 1'b1, "R6 pulse before reset", q, 1);
    #2 rst_n = 1'b0;
    #1 chk(q === 1'b0 && qn === 1'b1, "R6 immediate clear", q, 0);
    @(negedge clk); a = 1'b0;
    repeat (3) @(negedge clk); a = 1'b1;
    repeat (3) @(negedge clk);
    chk(q === 1'b0, "R6 trigger during reset", q, 0);
    rst_n = 1'b1;
    observe(30, hi);
    chk(hi == 0, "R7 level held across release", hi, 0);
    @(negedge clk); a = 1'b0;
    observe(10, hi);

    // R7 edge in the same cycle as release
    width = 16'd3;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; a = 1'b1;
    observe(30, hi);
    chk(hi == 0, "R7 edge at release", hi, 0);
    @(negedge clk); a = 1'b0;
    repeat (4) @(negedge clk); a = 1'b1;
    observe(20, hi);
    chk(hi == 4, "R7 trigger after recovery", hi, 4);
    @(negedge clk); a = 1'b0;

    // R7 fall_n held low across release
    @(negedge clk); rst_n = 1'b0; b = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    observe(30, hi);
    chk(hi == 0, "R7 fall_n low across release", hi, 0);
    @(negedge clk); b = 1'b1;
    observe(15, hi);
    chk(hi == 0, "R2 fall_n rise after reset", hi, 0);

    chk(compl_bad == 0, "R8 complement", compl_bad, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule